// File: doc/BRIEF.md
# Byte-Wide SPI Master Controller

This block is a memory-mapped SPI master that moves a single byte per transfer. Software programs a small byte-wide register file. It sets the clock polarity, clock phase and bit order. It sets the serial clock rate through a two-field divider and drives the slave-select pin through a port data and direction pair. Writing a byte to the data register starts a shift. The block generates the serial clock and MOSI, samples MISO, and raises a completion flag and interrupt when the eighth bit has been exchanged.

Software clears the completion flag in two steps: it reads the status register while the flag is set, then it reads the data register. A data write during a shift is discarded and flagged as a write collision. When the block is enabled as a master with its slave-select pin configured as an input, another device that pulls that pin low stops the shift and raises a separate fault interrupt. Clearing the enable bit aborts any shift, parks the clock at its idle level and wipes all flags.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, control 1 (0x00), control 2 (0x01), baud (0x04), status (0x05), data (0x09) and port direction (0x10) read 0x00. Port data (0x0D) reads 0x08. Both interrupt outputs are low.
- R2: The baud register keeps only bits 6:4 (P) and 2:0 (E), and its other bits read 0. Each SCK half period lasts (P+1)·2^E bus clocks. The first SCK edge comes that many clocks after the write that starts the byte.
- R3: A write to data (0x09) starts an 8-bit shift when control 1 bit 6 (enable) and bit 4 (master) are set and no shift is active. A shift produces exactly 16 SCK edges. Outside a shift, SCK equals control 1 bit 3 (CPOL).
- R4: With control 1 bit 2 (CPHA) clear, MISO is sampled on the odd-numbered edges counted from one, and MOSI changes on the even-numbered edges. With CPHA set, MOSI changes on the leading edges after the first, and MISO is sampled on the trailing edges.
- R5: With control 1 bit 0 set, bit 0 of the byte goes out and comes in first. Otherwise bit 7 does.
- R6: At the end of a shift, status bit 7 (done) is set and a data read returns the received byte. irq_done is high exactly when done and control 1 bit 7 (interrupt enable) are both set.
- R7: A status read taken while done or the collision flag is set, followed by a data read, clears both flags.
- R8: A data write during a shift sets status bit 6 (collision). The write has no effect on the byte in flight.
- R9: A mode fault occurs when the block is enabled as a master, port direction bit 3 is 0 and ss_n_i is low. It sets status bit 4, stops the shift and drives irq_fault when interrupts are enabled. A status read taken with the fault set, followed by a control 1 write, clears it.
- R10: With enable clear, any shift is stopped, SCK returns to CPOL and all status flags read 0.
- R11: ss_n_o follows port data bit 3. The output enables follow port direction bits 1 (MOSI), 2 (SCK) and 3 (SS).
- R12: A data write while the enable bit or the master bit is clear starts no shift and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives read side effects) |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| irq_done | output | 1 | Byte-complete interrupt |
| irq_fault | output | 1 | Mode-fault interrupt |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_n_o | output | 1 | Slave-select pin level |
| ss_n_i | input | 1 | Slave-select pin sensed level |
| sck_oe | output | 1 | SCK output enable |
| mosi_oe | output | 1 | MOSI output enable |
| ss_oe | output | 1 | SS output enable |

## Verification
The hardest states to reach are the ones where an event lands in the middle of a shift. These are a collision write part-way through a byte, a fault that stops the clock between edges, and an enable clear that must return SCK to its idle level at once. The bench reaches them with slow divider settings, so the shift spans hundreds of cycles, and fires each event at a chosen cycle count after the start. A behavioural model, built on edge counts and cycles since the start, predicts SCK, MOSI, flags and every register read on each clock. Every combination of CPOL, CPHA and bit order also runs against a bench-driven slave.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;
    localparam int ADDR_W  = 5;
    localparam int BYTE_W  = 8;
    localparam int FIELD_W = 3;
    localparam int EDGE_W  = $clog2(2 * BYTE_W);

    localparam logic [ADDR_W-1:0] ADR_CTL1 = 5'h00;
    localparam logic [ADDR_W-1:0] ADR_CTL2 = 5'h01;
    localparam logic [ADDR_W-1:0] ADR_BAUD = 5'h04;
    localparam logic [ADDR_W-1:0] ADR_STAT = 5'h05;
    localparam logic [ADDR_W-1:0] ADR_DATA = 5'h09;
    localparam logic [ADDR_W-1:0] ADR_PDAT = 5'h0D;
    localparam logic [ADDR_W-1:0] ADR_PDIR = 5'h10;

    // control 1 bit positions
    localparam int C_IE   = 7;
    localparam int C_EN   = 6;
    localparam int C_MSTR = 4;
    localparam int C_CPOL = 3;
    localparam int C_CPHA = 2;
    localparam int C_LSB  = 0;
    // status bit positions
    localparam int S_DONE  = 7;
    localparam int S_WCOL  = 6;
    localparam int S_FAULT = 4;
    // port bit positions
    localparam int P_MOSI = 1;
    localparam int P_SCK  = 2;
    localparam int P_SS   = 3;
    // baud field positions
    localparam int PRE_LSB = 4;
    localparam int EXP_LSB = 0;
    localparam logic [BYTE_W-1:0] BAUD_MASK =
        BYTE_W'((((1 << FIELD_W) - 1) << PRE_LSB) | (((1 << FIELD_W) - 1) << EXP_LSB));
    localparam logic [BYTE_W-1:0] PDAT_RST = BYTE_W'(1 << P_SS);

    typedef struct packed {
        logic              busy;
        logic              phase;
        logic [EDGE_W-1:0] edge_n;
        logic [BYTE_W-1:0] tx;
        logic [BYTE_W-1:0] rx;
    } eng_t;

    typedef struct packed {
        logic [BYTE_W-1:0] ctl1;
        logic [BYTE_W-1:0] ctl2;
        logic [BYTE_W-1:0] baud;
        logic [BYTE_W-1:0] pdat;
        logic [BYTE_W-1:0] pdir;
        logic              done;
        logic              wcol;
        logic              fault;
        logic              arm_clr;
        logic              arm_flt;
        logic [BYTE_W-1:0] rxbuf;
    } reg_t;
endpackage

// File: rtl/spi_baud_gen.sv
module spi_baud_gen
    import spi_byte_pkg::*;
#(
    parameter int FW = FIELD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [FW-1:0] presc,
    input  logic [FW-1:0] expo,
    output logic          tick
);
    localparam int MAX_HALF = (1 << FW) << ((1 << FW) - 1);
    localparam int CNT_W    = $clog2(MAX_HALF) + 1;

    logic [CNT_W-1:0] cnt_d, cnt_q, half_len;

    always_comb begin
        half_len = (CNT_W'(presc) + CNT_W'(1)) << expo;
        tick     = run && (cnt_q == half_len - CNT_W'(1));
        cnt_d    = (!run || tick) ? '0 : cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_IDLE_COUNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0)) else $error("counter not parked"); // R2
endmodule

// File: rtl/spi_shift_eng.sv
module spi_shift_eng
    import spi_byte_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic              tick,
    input  logic              cpha,
    input  logic              lsb_first,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              miso,
    output logic              busy,
    output logic              phase,
    output logic              mosi_bit,
    output logic              done,
    output logic [BYTE_W-1:0] rx_byte
);
    localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2 * BYTE_W - 1);

    eng_t eng_d, eng_q;
    logic leading, do_sample, do_shift;

    always_comb begin
        eng_d     = eng_q;
        done      = 1'b0;
        leading   = ~eng_q.edge_n[0];
        do_sample = cpha ? !leading : leading;
        do_shift  = cpha ? (leading && eng_q.edge_n != '0)
                         : (!leading && eng_q.edge_n != LAST_EDGE);
        if (abort) begin
            eng_d.busy   = 1'b0;
            eng_d.phase  = 1'b0;
            eng_d.edge_n = '0;
        end else if (start && !eng_q.busy) begin
            eng_d.busy   = 1'b1;
            eng_d.phase  = 1'b0;
            eng_d.edge_n = '0;
            eng_d.tx     = tx_byte;
        end else if (eng_q.busy && tick) begin
            eng_d.phase  = ~eng_q.phase;
            eng_d.edge_n = eng_q.edge_n + EDGE_W'(1);
            if (do_sample)
                eng_d.rx = lsb_first ? {miso, eng_q.rx[BYTE_W-1:1]}
                                     : {eng_q.rx[BYTE_W-2:0], miso};
            if (do_shift)
                eng_d.tx = lsb_first ? (eng_q.tx >> 1) : (eng_q.tx << 1);
            if (eng_q.edge_n == LAST_EDGE) begin
                eng_d.busy   = 1'b0;
                eng_d.edge_n = '0;
                done         = 1'b1;
            end
        end
        busy     = eng_q.busy;
        phase    = eng_q.phase;
        mosi_bit = eng_q.busy & (lsb_first ? eng_q.tx[0] : eng_q.tx[BYTE_W-1]);
        rx_byte  = eng_d.rx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    AST_PHASE_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_q.busy |-> !eng_q.phase) else $error("clock phase left toggled"); // R3
    AST_FULL_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(eng_q.busy) && !$past(abort)) |-> $past(eng_q.edge_n) == LAST_EDGE)
        else $error("byte ended early"); // R3
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
    import spi_byte_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              irq_done,
    output logic              irq_fault,
    output logic              sck_o,
    output logic              mosi_o,
    input  logic              miso_i,
    output logic              ss_n_o,
    input  logic              ss_n_i,
    output logic              sck_oe,
    output logic              mosi_oe,
    output logic              ss_oe
);
    reg_t regs_d, regs_q;

    logic en, mstr, fault_cond, abort, start;
    logic wr_data, rd_data, rd_stat, wr_ctl1;
    logic tick, eng_busy, eng_phase, eng_mosi, eng_done;
    logic [BYTE_W-1:0] eng_rx, stat_byte;

    spi_baud_gen #(.FW(FIELD_W)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (eng_busy),
        .presc (regs_q.baud[PRE_LSB +: FIELD_W]),
        .expo  (regs_q.baud[EXP_LSB +: FIELD_W]),
        .tick  (tick)
    );

    spi_shift_eng u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .abort     (abort),
        .tick      (tick),
        .cpha      (regs_q.ctl1[C_CPHA]),
        .lsb_first (regs_q.ctl1[C_LSB]),
        .tx_byte   (bus_wdata),
        .miso      (miso_i),
        .busy      (eng_busy),
        .phase     (eng_phase),
        .mosi_bit  (eng_mosi),
        .done      (eng_done),
        .rx_byte   (eng_rx)
    );

    always_comb begin
        en         = regs_q.ctl1[C_EN];
        mstr       = regs_q.ctl1[C_MSTR];
        fault_cond = en & mstr & ~regs_q.pdir[P_SS] & ~ss_n_i;
        abort      = ~en | fault_cond;
        wr_data    = bus_wr && (bus_addr == ADR_DATA);
        wr_ctl1    = bus_wr && (bus_addr == ADR_CTL1);
        rd_data    = bus_rd && (bus_addr == ADR_DATA);
        rd_stat    = bus_rd && (bus_addr == ADR_STAT);
        start      = wr_data & en & mstr & ~eng_busy & ~abort;

        regs_d = regs_q;
        if (bus_wr) begin
            case (bus_addr)
                ADR_CTL1: regs_d.ctl1 = bus_wdata;
                ADR_CTL2: regs_d.ctl2 = bus_wdata;
                ADR_BAUD: regs_d.baud = bus_wdata & BAUD_MASK;
                ADR_PDAT: regs_d.pdat = bus_wdata;
                ADR_PDIR: regs_d.pdir = bus_wdata;
                default: ;
            endcase
        end
        if (rd_stat) begin
            regs_d.arm_clr = regs_q.done | regs_q.wcol;
            regs_d.arm_flt = regs_q.fault;
        end
        if (rd_data) begin
            if (regs_q.arm_clr) begin
                regs_d.done = 1'b0;
                regs_d.wcol = 1'b0;
            end
            regs_d.arm_clr = 1'b0;
        end
        if (wr_ctl1 && regs_q.arm_flt) begin
            regs_d.fault   = 1'b0;
            regs_d.arm_flt = 1'b0;
        end
        if (eng_done) begin
            regs_d.done  = 1'b1;
            regs_d.rxbuf = eng_rx;
        end
        if (wr_data && eng_busy && !abort) regs_d.wcol = 1'b1;
        if (fault_cond) regs_d.fault = 1'b1;
        if (!en) begin
            regs_d.done    = 1'b0;
            regs_d.wcol    = 1'b0;
            regs_d.fault   = 1'b0;
            regs_d.arm_clr = 1'b0;
            regs_d.arm_flt = 1'b0;
        end

        stat_byte          = '0;
        stat_byte[S_DONE]  = regs_q.done;
        stat_byte[S_WCOL]  = regs_q.wcol;
        stat_byte[S_FAULT] = regs_q.fault;
        case (bus_addr)
            ADR_CTL1: bus_rdata = regs_q.ctl1;
            ADR_CTL2: bus_rdata = regs_q.ctl2;
            ADR_BAUD: bus_rdata = regs_q.baud;
            ADR_STAT: bus_rdata = stat_byte;
            ADR_DATA: bus_rdata = regs_q.rxbuf;
            ADR_PDAT: bus_rdata = regs_q.pdat;
            ADR_PDIR: bus_rdata = regs_q.pdir;
            default:  bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q      <= '0;
            regs_q.pdat <= PDAT_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign sck_o     = regs_q.ctl1[C_CPOL] ^ eng_phase;
    assign mosi_o    = eng_mosi;
    assign ss_n_o    = regs_q.pdat[P_SS];
    assign sck_oe    = regs_q.pdir[P_SCK];
    assign mosi_oe   = regs_q.pdir[P_MOSI];
    assign ss_oe     = regs_q.pdir[P_SS];
    assign irq_done  = regs_q.ctl1[C_IE] & regs_q.done;
    assign irq_fault = regs_q.ctl1[C_IE] & regs_q.fault;

    AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |-> (sck_o == regs_q.ctl1[C_CPOL])) else $error("sck not idle"); // R3
    AST_START_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> eng_busy) else $error("shift not started"); // R3
    AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> regs_q.done) else $error("done flag missing"); // R6
    AST_WCOL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && eng_busy && !abort) |=> regs_q.wcol) else $error("collision missed"); // R8
    AST_FAULT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        fault_cond |=> (!eng_busy && regs_q.fault)) else $error("fault not handled"); // R9
    AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!eng_busy && !regs_q.done && !regs_q.wcol)) else $error("disable ignored"); // R10
endmodule

// File: tb/tb_spi_byte_master.sv
module tb_spi_byte_master;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_done, irq_fault, sck_o, mosi_o, ss_n_o, sck_oe, mosi_oe, ss_oe;
    logic       miso_i = 1'b0, ss_n_i = 1'b1;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    logic [7:0] slave_byte = 8'h00;

    spi_byte_master dut (.*);

    always #4 clk = ~clk;

    // reference model state
    logic [7:0] m_ctl1 = 0, m_ctl2 = 0, m_baud = 0, m_pdat = 8'h08, m_pdir = 0, m_rx = 0;
    logic [7:0] m_tx = 0, m_sl = 0;
    bit m_busy = 0, m_done = 0, m_wcol = 0, m_fault = 0, m_arm = 0, m_armf = 0;
    bit m_cpha = 0, m_lsb = 0;
    int m_n = 0, m_half = 1;

    function automatic int bit_idx(int e, bit ph);
        int j;
        j = ph ? ((e == 0) ? 0 : (e - 1) / 2) : e / 2;
        if (j > 7) j = 7;
        return j;
    endfunction

    always @(posedge clk) begin
        bit wd, rs, rdd, wc1, en, ms, fc, ab, was_busy, fin;
        if (!rst_n) begin
            m_ctl1 = 0; m_ctl2 = 0; m_baud = 0; m_pdat = 8'h08; m_pdir = 0; m_rx = 0;
            m_busy = 0; m_done = 0; m_wcol = 0; m_fault = 0; m_arm = 0; m_armf = 0;
        end else begin
            wd  = bus_wr && bus_addr == 5'h09;
            wc1 = bus_wr && bus_addr == 5'h00;
            rs  = bus_rd && bus_addr == 5'h05;
            rdd = bus_rd && bus_addr == 5'h09;
            en = m_ctl1[6]; ms = m_ctl1[4];
            fc = en && ms && !m_pdir[3] && !ss_n_i;
            ab = !en || fc;
            was_busy = m_busy; fin = 0;
            if (ab) m_busy = 0;
            else if (m_busy) begin
                m_n++;
                if (m_n == 16 * m_half) begin m_busy = 0; fin = 1; end
            end else if (wd && ms) begin
                m_busy = 1; m_n = 0; m_tx = bus_wdata; m_sl = slave_byte;
                m_half = (int'(m_baud[6:4]) + 1) << m_baud[2:0];
                m_cpha = m_ctl1[2]; m_lsb = m_ctl1[0];
            end
            if (bus_wr) case (bus_addr)
                5'h00: m_ctl1 = bus_wdata;
                5'h01: m_ctl2 = bus_wdata;
                5'h04: m_baud = bus_wdata & 8'h77;
                5'h0D: m_pdat = bus_wdata;
                5'h10: m_pdir = bus_wdata;
                default: ;
            endcase
            if (rs) begin m_arm = m_done | m_wcol; m_armf = m_fault; end
            if (rdd) begin
                if (m_arm) begin m_done = 0; m_wcol = 0; end
                m_arm = 0;
            end
            if (wc1 && m_armf) begin m_fault = 0; m_armf = 0; end
            if (fin) begin m_done = 1; m_rx = m_sl; end
            if (wd && was_busy && !ab) m_wcol = 1;
            if (fc) m_fault = 1;
            if (!en) begin m_done = 0; m_wcol = 0; m_fault = 0; m_arm = 0; m_armf = 0; end
        end
    end

    task automatic cmp(string tag, string what, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at cycle %0d", tag, what, act, exp, cyc);
        end
    endtask

    function automatic logic [7:0] model_read(logic [4:0] a);
        case (a)
            5'h00: return m_ctl1;
            5'h01: return m_ctl2;
            5'h04: return m_baud;
            5'h05: return {m_done, m_wcol, 1'b0, m_fault, 4'b0};
            5'h09: return m_rx;
            5'h0D: return m_pdat;
            5'h10: return m_pdir;
            default: return 8'h00;
        endcase
    endfunction

    // per-cycle comparison and slave drive
    always @(negedge clk) begin
        int e, j;
        if (rst_n) begin
            e = m_n / m_half;
            cmp("R2 R3 R10", "sck", {7'b0, sck_o},
                {7'b0, m_ctl1[3] ^ (m_busy ? e[0] : 1'b0)});
            if (m_busy) begin
                j = bit_idx(e, m_cpha);
                cmp("R4 R5", "mosi", {7'b0, mosi_o},
                    {7'b0, m_lsb ? m_tx[j] : m_tx[7 - j]});
            end
            cmp("R6", "irq_done", {7'b0, irq_done}, {7'b0, m_ctl1[7] & m_done});
            cmp("R9", "irq_fault", {7'b0, irq_fault}, {7'b0, m_ctl1[7] & m_fault});
            cmp("R11", "pins", {4'b0, ss_n_o, sck_oe, mosi_oe, ss_oe},
                {4'b0, m_pdat[3], m_pdir[2], m_pdir[1], m_pdir[3]});
            if (bus_rd)
                cmp(bus_addr == 5'h05 ? "R7 R8 R9 R12" :
                    bus_addr == 5'h09 ? "R6" : "R1 R2", "rdata",
                    bus_rdata, model_read(bus_addr));
            if (m_busy) begin
                j = bit_idx(e, m_cpha);
                miso_i = m_lsb ? m_sl[j] : m_sl[7 - j];
            end else miso_i = 1'b0;
        end
    end

    task automatic wr(logic [4:0] a, logic [7:0] d);
        @(posedge clk); #1;
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 0;
    endtask

    task automatic rd(logic [4:0] a, output logic [7:0] v);
        @(posedge clk); #1;
        bus_rd = 1; bus_addr = a;
        @(negedge clk); v = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 0;
    endtask

    task automatic idle(int k);
        repeat (k) @(posedge clk);
    endtask

    task automatic wait_byte();
        while (m_busy) @(posedge clk);
        idle(2);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] bauds [8] = '{8'h00, 8'h10, 8'h21, 8'h32, 8'h03, 8'h11, 8'h70, 8'h07};
        idle(3); #1 rst_n = 1;
        // R1 reset values
        rd(5'h00, v); cmp("R1", "ctl1", v, 8'h00);
        rd(5'h05, v); cmp("R1", "status", v, 8'h00);
        rd(5'h0D, v); cmp("R1", "pdat", v, 8'h08);
        rd(5'h10, v); cmp("R1", "pdir", v, 8'h00);
        // R11 port
        wr(5'h10, 8'h0E); wr(5'h0D, 8'h00); idle(2); wr(5'h0D, 8'h08);
        // R2 baud masking
        wr(5'h04, 8'hFF); rd(5'h04, v); cmp("R2", "baud mask", v, 8'h77);
        // R12 write while disabled or not master
        wr(5'h04, 8'h00); wr(5'h00, 8'h90);
        wr(5'h09, 8'h55); idle(20);
        rd(5'h05, v); cmp("R12", "status after ignored write", v, 8'h00);
        wr(5'h00, 8'hC0); wr(5'h09, 8'h55); idle(20);
        rd(5'h05, v); cmp("R12", "status slave mode", v, 8'h00);
        // all modes, several dividers
        for (int m = 0; m < 8; m++) begin
            wr(5'h00, 8'hD0 | (m[0] ? 8'h08 : 8'h00) | (m[1] ? 8'h04 : 8'h00) |
                      (m[2] ? 8'h01 : 8'h00));
            wr(5'h04, bauds[m]);
            slave_byte = 8'h3C ^ 8'(m * 37);
            wr(5'h09, 8'hA5 ^ 8'(m * 11));
            wait_byte();
            rd(5'h05, v); cmp("R6", "done flag", v, 8'h80);
            rd(5'h09, v); cmp("R4 R5", "received byte", v, slave_byte);
            rd(5'h05, v); cmp("R7", "cleared", v, 8'h00);
        end
        // R8 collision mid-byte
        wr(5'h00, 8'hD4); wr(5'h04, 8'h32);
        slave_byte = 8'h96; wr(5'h09, 8'h5A); idle(60);
        wr(5'h09, 8'hFF); wait_byte();
        rd(5'h05, v); cmp("R8", "done+collision", v, 8'hC0);
        rd(5'h09, v); cmp("R8", "byte unaffected", v, 8'h96);
        rd(5'h05, v); cmp("R7", "both cleared", v, 8'h00);
        // R7 data read without prior status read does not clear
        wr(5'h04, 8'h00); wr(5'h09, 8'h81); wait_byte();
        rd(5'h09, v); rd(5'h05, v); cmp("R7", "not cleared by data read alone", v, 8'h80);
        rd(5'h09, v);
        // R9 mode fault
        wr(5'h10, 8'h06); wr(5'h04, 8'h21);
        wr(5'h09, 8'hC3); idle(25);
        @(posedge clk); #1 ss_n_i = 0; idle(3); #1 ss_n_i = 1; idle(3);
        cmp("R9", "irq_fault", {7'b0, irq_fault}, 8'h01);
        rd(5'h05, v); cmp("R9", "fault status", v, 8'h10);
        wr(5'h00, 8'hD0); rd(5'h05, v); cmp("R9", "fault cleared", v, 8'h00);
        wr(5'h10, 8'h0E);
        // R10 disable mid-byte
        wr(5'h00, 8'hD8); wr(5'h04, 8'h32); wr(5'h09, 8'h0F); idle(50);
        wr(5'h00, 8'h98); idle(5);
        cmp("R10", "sck parked", {7'b0, sck_o}, 8'h01);
        rd(5'h05, v); cmp("R10", "flags clear", v, 8'h00);
        idle(10);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule